// File: doc/BRIEF.md
# Two-Level Translation Table Walker

This block resolves a 32-bit virtual address into a physical address after a translation lookaside miss. It reads a first-level descriptor from memory, decodes its type, and then either reports a result at once or reads one more descriptor from a coarse second-level table. Each walk ends with a physical address, a mapping size, the attribute flags of the mapping and a fault code. Four mapping sizes are supported: 4KB small pages, 64KB large pages, 1MB sections and 16MB supersections.

The requester presents a virtual address and a table base together with a one-cycle start strobe. The walker is busy from acceptance until it raises its done strobe, and it ignores new starts while busy. Descriptors are fetched over a read port with a request/ready handshake and a separate response strobe, with one read outstanding at a time. The result outputs are valid in the cycle of the done strobe and hold their value until the next walk finishes.

Top module: `ptw_walker`

## Requirements
- R1: The first-level read address is the table base with bits [13:0] cleared, combined with virtual address bits [31:20] placed at bits [13:2] and zeros at bits [1:0].
- R2: A first-level descriptor whose low two bits are 00 or 11 ends the walk after one read with fault code 1, physical address 0, size code 0 and all attribute outputs 0.
- R3: A first-level type 10 descriptor with bit 18 clear maps a 1MB section: size code 2, physical address = descriptor [31:20] with virtual address [19:0], fault code 0, one read only.
- R4: A first-level type 10 descriptor with bit 18 set maps a 16MB supersection: size code 3, physical address = descriptor [31:24] with virtual address [23:0], fault code 0.
- R5: A first-level type 01 descriptor starts a second read at address descriptor [31:10] with virtual address [19:12] placed at bits [9:2] and zeros at [1:0]; the non-secure output of the resulting mapping is first-level descriptor bit 3.
- R6: A second-level descriptor with low bits 00 ends the walk with fault code 2, physical address 0, size code 0 and all attribute outputs 0.
- R7: A second-level type 01 descriptor maps a 64KB page: size code 1, physical address = descriptor [31:16] with virtual address [15:0]; execute-never is bit 15, type extension bits [14:12], access bits {bit 9, bits [5:4]}, shared bit 10, not-global bit 11.
- R8: A second-level descriptor with bit 1 set maps a 4KB page: size code 0, physical address = descriptor [31:12] with virtual address [11:0]; execute-never is bit 0, type extension bits [8:6], access bits {bit 9, bits [5:4]}, shared bit 10, not-global bit 11.
- R9: For sections and supersections the attributes come from the first-level descriptor: execute-never bit 4, access bits {bit 15, bits [11:10]}, type extension bits [14:12], shared bit 16, not-global bit 17, non-secure bit 19.
- R10: Busy rises the cycle after a start is accepted in idle and falls the cycle after the one-cycle done strobe; starts while busy are ignored; a memory request holds its address until ready, and no request is raised in the done cycle.
- R11: After reset, busy, done, the memory request and the fault code are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| walk_start | input | 1 | Start strobe, taken only when idle |
| walk_va | input | 32 | Virtual address to translate |
| walk_ttb | input | 32 | First-level table base |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle result strobe |
| mem_req_valid | output | 1 | Descriptor read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Descriptor byte address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Descriptor word |
| res_pa | output | 32 | Physical address |
| res_size | output | 2 | 0 = 4KB, 1 = 64KB, 2 = 1MB, 3 = 16MB |
| res_fault | output | 2 | 0 = none, 1 = first-level fault, 2 = second-level fault |
| res_ng | output | 1 | Not-global flag |
| res_shared | output | 1 | Shared flag |
| res_xn | output | 1 | Execute-never flag |
| res_ap | output | 3 | Access bits {extension, ap[1:0]} |
| res_tex | output | 3 | Type extension field |
| res_ns | output | 1 | Non-secure attribute |

## Verification
A wrong state transition shows within one response: a missing or extra second read appears as an unexpected request address or a done strobe one handshake early or late, which the bench catches at the next falling edge. A mis-sliced descriptor or a wrong offset mask shows as a wrong physical address or attribute in the done cycle of that very walk, so each type code is swept against several virtual addresses and pseudo-random descriptor bodies. Handshake errors, such as an address changing before ready or a start accepted mid-walk, show as a changed address or a result drawn from the wrong virtual address on the same walk.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  localparam int AW          = 32;
  localparam int TTB_LSB     = 14;
  localparam int L1_IDX_LSB  = 20;
  localparam int L2_IDX_LSB  = 12;
  localparam int COARSE_LSB  = 10;
  localparam int SS_SEL_BIT  = 18;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_L1_REQ  = 3'd1,
    ST_L1_WAIT = 3'd2,
    ST_L2_REQ  = 3'd3,
    ST_L2_WAIT = 3'd4,
    ST_DONE    = 3'd5
  } wstate_e;

  typedef enum logic [1:0] {
    SZ_4K  = 2'd0,
    SZ_64K = 2'd1,
    SZ_1M  = 2'd2,
    SZ_16M = 2'd3
  } psize_e;

  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_LVL1 = 2'd1,
    FLT_LVL2 = 2'd2
  } fault_e;

  typedef struct packed {
    logic       ng;
    logic       shared;
    logic       xn;
    logic [2:0] ap;
    logic [2:0] tex;
    logic       ns;
  } attr_t;

  typedef struct packed {
    logic [AW-1:0] pa;
    psize_e        size;
    attr_t         attr;
    fault_e        fault;
  } walk_res_t;

  function automatic logic [AW-1:0] l1_desc_addr(input logic [AW-1:0] ttb,
                                                  input logic [AW-1:0] va);
    l1_desc_addr = {ttb[AW-1:TTB_LSB], va[AW-1:L1_IDX_LSB], 2'b00};
  endfunction

  function automatic logic [AW-1:0] l2_desc_addr(input logic [AW-1:COARSE_LSB] base,
                                                  input logic [AW-1:0] va);
    l2_desc_addr = {base, va[L1_IDX_LSB-1:L2_IDX_LSB], 2'b00};
  endfunction

  function automatic logic [AW-1:0] offset_mask(input psize_e sz);
    case (sz)
      SZ_16M:  offset_mask = 32'h00FF_FFFF;
      SZ_1M:   offset_mask = 32'h000F_FFFF;
      SZ_64K:  offset_mask = 32'h0000_FFFF;
      default: offset_mask = 32'h0000_0FFF;
    endcase
  endfunction

  function automatic logic [AW-1:0] splice_pa(input logic [AW-1:0] desc,
                                               input logic [AW-1:0] va,
                                               input psize_e        sz);
    logic [AW-1:0] m;
    m = offset_mask(sz);
    splice_pa = (desc & ~m) | (va & m);
  endfunction

endpackage

// File: rtl/ptw_l1_decode.sv
module ptw_l1_decode
  import ptw_pkg::*;
(
  input  logic [AW-1:0]         desc,
  input  logic [AW-1:0]         va,
  output logic                  is_fault,
  output logic                  is_table,
  output walk_res_t             leaf,
  output logic [AW-1:COARSE_LSB] coarse_base,
  output logic                  table_ns
);

  logic [1:0] kind;
  psize_e     sz;

  assign kind        = desc[1:0];
  assign is_table    = (kind == 2'b01);
  assign is_fault    = (kind == 2'b00) || (kind == 2'b11);
  assign coarse_base = desc[AW-1:COARSE_LSB];
  assign table_ns    = desc[3];
  assign sz          = desc[SS_SEL_BIT] ? SZ_16M : SZ_1M;

  always_comb begin
    leaf = '0;
    if (kind == 2'b10) begin
      leaf.size        = sz;
      leaf.pa          = splice_pa(desc, va, sz);
      leaf.attr.xn     = desc[4];
      leaf.attr.ap     = {desc[15], desc[11:10]};
      leaf.attr.tex    = desc[14:12];
      leaf.attr.shared = desc[16];
      leaf.attr.ng     = desc[17];
      leaf.attr.ns     = desc[19];
      leaf.fault       = FLT_NONE;
    end else if (is_fault) begin
      leaf.fault = FLT_LVL1;
    end
  end

endmodule

// File: rtl/ptw_l2_decode.sv
module ptw_l2_decode
  import ptw_pkg::*;
(
  input  logic [AW-1:0] desc,
  input  logic [AW-1:0] va,
  input  logic          ns,
  output walk_res_t     res
);

  logic is_small;
  logic is_large;

  assign is_small = desc[1];
  assign is_large = (desc[1:0] == 2'b01);

  always_comb begin
    res = '0;
    if (is_small) begin
      res.size        = SZ_4K;
      res.pa          = splice_pa(desc, va, SZ_4K);
      res.attr.xn     = desc[0];
      res.attr.tex    = desc[8:6];
    end else if (is_large) begin
      res.size        = SZ_64K;
      res.pa          = splice_pa(desc, va, SZ_64K);
      res.attr.xn     = desc[15];
      res.attr.tex    = desc[14:12];
    end
    if (is_small || is_large) begin
      res.attr.ap     = {desc[9], desc[5:4]};
      res.attr.shared = desc[10];
      res.attr.ng     = desc[11];
      res.attr.ns     = ns;
      res.fault       = FLT_NONE;
    end else begin
      res.fault = FLT_LVL2;
    end
  end

endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import ptw_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    start,
  input  logic    req_ready,
  input  logic    rsp_valid,
  input  logic    l1_table,
  output wstate_e state,
  output logic    accept,
  output logic    l1_take,
  output logic    l2_take,
  output logic    req_valid,
  output logic    busy,
  output logic    done
);

  wstate_e nxt;

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE:    if (start)     nxt = ST_L1_REQ;
      ST_L1_REQ:  if (req_ready) nxt = ST_L1_WAIT;
      ST_L1_WAIT: if (rsp_valid) nxt = l1_table ? ST_L2_REQ : ST_DONE;
      ST_L2_REQ:  if (req_ready) nxt = ST_L2_WAIT;
      ST_L2_WAIT: if (rsp_valid) nxt = ST_DONE;
      ST_DONE:                   nxt = ST_IDLE;
      default:                   nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end

  assign accept    = (state == ST_IDLE) && start;
  assign l1_take   = (state == ST_L1_WAIT) && rsp_valid;
  assign l2_take   = (state == ST_L2_WAIT) && rsp_valid;
  assign req_valid = (state == ST_L1_REQ) || (state == ST_L2_REQ);
  assign busy      = (state != ST_IDLE);
  assign done      = (state == ST_DONE);

endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          walk_start,
  input  logic [31:0]   walk_va,
  input  logic [31:0]   walk_ttb,
  output logic          busy,
  output logic          done,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic [31:0]   mem_req_addr,
  input  logic          mem_rsp_valid,
  input  logic [31:0]   mem_rsp_data,
  output logic [31:0]   res_pa,
  output logic [1:0]    res_size,
  output logic [1:0]    res_fault,
  output logic          res_ng,
  output logic          res_shared,
  output logic          res_xn,
  output logic [2:0]    res_ap,
  output logic [2:0]    res_tex,
  output logic          res_ns
);

  wstate_e               state;
  logic                  walk_accept;
  logic                  l1_rsp_take;
  logic                  l2_rsp_take;
  logic                  l1_is_fault;
  logic                  l1_is_table;
  walk_res_t             l1_leaf;
  walk_res_t             l2_res;
  logic [AW-1:COARSE_LSB] l1_coarse;
  logic                  l1_ns;

  logic [AW-1:0]          va_q;
  logic [AW-1:0]          ttb_q;
  logic [AW-1:COARSE_LSB] coarse_q;
  logic                  ns_q;
  walk_res_t             res_q;

  ptw_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (walk_start),
    .req_ready (mem_req_ready),
    .rsp_valid (mem_rsp_valid),
    .l1_table  (l1_is_table),
    .state     (state),
    .accept    (walk_accept),
    .l1_take   (l1_rsp_take),
    .l2_take   (l2_rsp_take),
    .req_valid (mem_req_valid),
    .busy      (busy),
    .done      (done)
  );

  ptw_l1_decode u_l1 (
    .desc        (mem_rsp_data),
    .va          (va_q),
    .is_fault    (l1_is_fault),
    .is_table    (l1_is_table),
    .leaf        (l1_leaf),
    .coarse_base (l1_coarse),
    .table_ns    (l1_ns)
  );

  ptw_l2_decode u_l2 (
    .desc (mem_rsp_data),
    .va   (va_q),
    .ns   (ns_q),
    .res  (l2_res)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      va_q     <= '0;
      ttb_q    <= '0;
      coarse_q <= '0;
      ns_q     <= 1'b0;
      res_q    <= '0;
    end else begin
      if (walk_accept) begin
        va_q  <= walk_va;
        ttb_q <= walk_ttb;
      end
      if (l1_rsp_take) begin
        if (l1_is_table) begin
          coarse_q <= l1_coarse;
          ns_q     <= l1_ns;
        end else begin
          res_q <= l1_leaf;
        end
      end
      if (l2_rsp_take) res_q <= l2_res;
    end
  end

  assign mem_req_addr = (state == ST_L2_REQ) ? l2_desc_addr(coarse_q, va_q)
                                             : l1_desc_addr(ttb_q, va_q);

  assign res_pa     = res_q.pa;
  assign res_size   = res_q.size;
  assign res_fault  = res_q.fault;
  assign res_ng     = res_q.attr.ng;
  assign res_shared = res_q.attr.shared;
  assign res_xn     = res_q.attr.xn;
  assign res_ap     = res_q.attr.ap;
  assign res_tex    = res_q.attr.tex;
  assign res_ns     = res_q.attr.ns;

endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        walk_accept,
  input logic        busy,
  input logic        done,
  input logic        mem_req_valid,
  input logic        mem_req_ready,
  input logic [31:0] mem_req_addr,
  input logic [31:0] va_q,
  input logic [31:0] res_pa,
  input logic [1:0]  res_size,
  input logic [1:0]  res_fault
);

  a_r10_req_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> busy);

  a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  a_r10_done_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, mem_req_valid}));

  a_r10_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    walk_accept |=> busy);

  a_r10_busy_fall_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(done));

  a_r2_l1_fault_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (done && res_fault == 2'd1) |-> (res_pa == 32'd0 && res_size == 2'd0));

  a_r6_l2_fault_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (done && res_fault == 2'd2) |-> (res_pa == 32'd0 && res_size == 2'd0));

  a_r3_section_offset: assert property (@(posedge clk) disable iff (!rst_n)
    (done && res_fault == 2'd0 && res_size == 2'd2) |-> (res_pa[19:0] == va_q[19:0]));

  a_r8_small_offset: assert property (@(posedge clk) disable iff (!rst_n)
    (done && res_fault == 2'd0 && res_size == 2'd0) |-> (res_pa[11:0] == va_q[11:0]));

endmodule

bind ptw_walker ptw_walker_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .walk_accept   (walk_accept),
  .busy          (busy),
  .done          (done),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .va_q          (va_q),
  .res_pa        (res_pa),
  .res_size      (res_size),
  .res_fault     (res_fault)
);

// File: tb/ptw_walker_tb.sv
module ptw_walker_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        walk_start = 1'b0;
  logic [31:0] walk_va = '0;
  logic [31:0] walk_ttb = '0;
  logic        busy, done, mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic [31:0] res_pa;
  logic [1:0]  res_size, res_fault;
  logic        res_ng, res_shared, res_xn, res_ns;
  logic [2:0]  res_ap, res_tex;

  int checks = 0;
  int failures = 0;
  logic [31:0] seed = 32'h1234_5678;

  always #2 clk = ~clk;

  ptw_walker u_dut (
    .clk (clk), .rst_n (rst_n),
    .walk_start (walk_start), .walk_va (walk_va), .walk_ttb (walk_ttb),
    .busy (busy), .done (done),
    .mem_req_valid (mem_req_valid), .mem_req_ready (mem_req_ready),
    .mem_req_addr (mem_req_addr), .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data (mem_rsp_data),
    .res_pa (res_pa), .res_size (res_size), .res_fault (res_fault),
    .res_ng (res_ng), .res_shared (res_shared), .res_xn (res_xn),
    .res_ap (res_ap), .res_tex (res_tex), .res_ns (res_ns)
  );

  task automatic chk(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] next_rand();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  task automatic do_walk(input logic [31:0] va, input logic [31:0] ttb,
                         input logic [31:0] d1, input logic [31:0] d2,
                         input int lat, input int rlat, input string tag);
    logic [31:0] e_a1, e_a2, e_pa;
    logic [1:0]  e_size, e_fault;
    logic [9:0]  e_attr;
    int          e_reads;
    logic [31:0] got_a1, got_a2;
    int          reads;
    int          guard;
    string       atag;
    // expected model, bit slices written from the requirements
    e_a1 = {ttb[31:14], 14'd0} | ({20'd0, va[31:20]} << 2);
    e_a2 = {d1[31:10], 10'd0} | ({24'd0, va[19:12]} << 2);
    e_pa = 0; e_size = 0; e_fault = 0; e_attr = 0; e_reads = 1;
    atag = tag;
    case (d1[1:0])
      2'b00, 2'b11: e_fault = 2'd1;
      2'b10: begin
        atag = "R9";
        if (d1[18]) begin e_size = 2'd3; e_pa = {d1[31:24], va[23:0]}; end
        else        begin e_size = 2'd2; e_pa = {d1[31:20], va[19:0]}; end
        // attr order {ng, shared, xn, ap[2:0], tex[2:0], ns}
        e_attr = {d1[17], d1[16], d1[4], d1[15], d1[11:10], d1[14:12], d1[19]};
      end
      default: begin
        e_reads = 2;
        if (d2[1]) begin
          e_size = 2'd0; e_pa = {d2[31:12], va[11:0]};
          e_attr = {d2[11], d2[10], d2[0], d2[9], d2[5:4], d2[8:6], d1[3]};
        end else if (d2[0]) begin
          e_size = 2'd1; e_pa = {d2[31:16], va[15:0]};
          e_attr = {d2[11], d2[10], d2[15], d2[9], d2[5:4], d2[14:12], d1[3]};
        end else begin
          e_fault = 2'd2;
        end
      end
    endcase

    @(negedge clk);
    walk_start = 1'b1; walk_va = va; walk_ttb = ttb;
    @(negedge clk);
    walk_start = 1'b0;
    chk("R10", "busy after start", {63'd0, busy}, 64'd1);
    reads = 0; got_a1 = 0; got_a2 = 0; guard = 0;
    while (!done && guard < 200) begin
      guard++;
      if (mem_req_valid) begin
        if (reads == 0) got_a1 = mem_req_addr; else got_a2 = mem_req_addr;
        for (int k = 0; k < lat; k++) begin
          if (k == 0) begin walk_start = 1'b1; walk_va = ~va; walk_ttb = ~ttb; end
          @(negedge clk);
          walk_start = 1'b0;
        end
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        for (int k = 0; k < rlat; k++) @(negedge clk);
        mem_rsp_valid = 1'b1;
        mem_rsp_data = (reads == 0) ? d1 : d2;
        @(negedge clk);
        mem_rsp_valid = 1'b0;
        mem_rsp_data = 32'hDEAD_BEEF;
        reads++;
      end else begin
        @(negedge clk);
      end
    end
    chk(tag, "done seen", {63'd0, done}, 64'd1);
    chk("R1", "first read address", {32'd0, got_a1}, {32'd0, e_a1});
    chk(tag, "read count", 64'(reads), 64'(e_reads));
    if (e_reads == 2) chk("R5", "second read address", {32'd0, got_a2}, {32'd0, e_a2});
    chk(tag, "fault code", {62'd0, res_fault}, {62'd0, e_fault});
    chk(tag, "physical address", {32'd0, res_pa}, {32'd0, e_pa});
    chk(tag, "size code", {62'd0, res_size}, {62'd0, e_size});
    chk(atag, "attributes", {54'd0, res_ng, res_shared, res_xn, res_ap, res_tex, res_ns},
        {54'd0, e_attr});
    @(negedge clk);
    chk("R10", "idle after done", {62'd0, busy, done}, 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL R10 watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    int idx;
    logic [31:0] vas [3];
    vas[0] = 32'h0000_0000;
    vas[1] = 32'hFFFF_FFFF;
    vas[2] = 32'h89AB_CDEF;
    repeat (3) @(negedge clk);
    chk("R11", "reset outputs", {59'd0, busy, done, mem_req_valid, res_fault},
        64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11", "idle after reset", {61'd0, busy, done, mem_req_valid}, 64'd0);
    idx = 0;
    for (int t1 = 0; t1 < 4; t1++) begin
      for (int sb = 0; sb < 2; sb++) begin
        for (int vi = 0; vi < 3; vi++) begin
          for (int t2 = 0; t2 < ((t1 == 1) ? 4 : 1); t2++) begin
            logic [31:0] d1, d2, ttb, va;
            string tg;
            va  = vas[vi] ^ (next_rand() & 32'h0F0F_0F0F);
            ttb = next_rand();
            d1  = {next_rand()[31:2], 2'(t1)};
            d1[18] = sb[0];
            d2  = {next_rand()[31:2], 2'(t2)};
            if (t1 == 0 || t1 == 3) tg = "R2";
            else if (t1 == 2)       tg = sb[0] ? "R4" : "R3";
            else if (t2 == 0)       tg = "R6";
            else if (t2 == 1)       tg = "R7";
            else                    tg = "R8";
            do_walk(va, ttb, d1, d2, idx % 3, idx % 2, tg);
            idx++;
          end
        end
      end
    end
    summary();
    $finish;
  end

endmodule